// File: doc/BRIEF.md
# Preloaded Commutation Control Latch

This block keeps the output-enable, complementary-enable and output-mode fields for a group of PWM channels and decides when a freshly written value reaches the active fields that feed the output stage. Software writes one channel's fields at a time through a simple register-write port. A preload bit selects whether those writes act at once or wait in shadow storage for a commutation event.

A commutation event comes from a one-cycle software generate strobe. When the update-select bit is set, a rising edge on the asynchronous trigger input also produces one; the trigger is synchronised first. Double buffering applies only to the low-numbered channels that own a complementary output. The remaining channels always take a write at once, and their complementary-enable field stays at zero. Every event sets a sticky status flag, which software clears by writing zero to it.

Top module: `pcc_latch`

## Requirements
- R1: During and after reset, every active field, every shadow field, the preload bit, the update-select bit, the generate bit and the status flag are 0.
- R2: With the preload bit at 0, a channel write reaches that channel's active fields at the clock edge that accepts the write.
- R3: With the preload bit at 1, a write to a complementary channel leaves its active fields unchanged. The value held in shadow moves to the active fields at the edge that ends an event cycle.
- R4: With the update-select bit at 0, trigger edges produce no event: active fields stay put and the flag stays clear.
- R5: With the update-select bit at 1, a 0-to-1 change on the trigger input shows on the active fields and the flag after the third rising clock edge that samples the new level.
- R6: A software generate strobe produces an event whatever the update-select bit holds, visible after the edge that accepts the strobe.
- R7: Channels at index NUM_COMP and above ignore the preload bit and update at once. Their complementary-enable output is always 0.
- R8: When a channel write and an event fall in the same cycle, the newly written value becomes active at that edge.
- R9: The generate bit reads 1 for the single cycle after a strobe and returns to 0 by itself.
- R10: The status flag sets on every event and stays set. A flag write with data 0 clears it. A flag write with data 1 has no effect. An event in the same cycle as a clear leaves the flag set.
- R11: A trigger held high produces exactly one event, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_wr | input | 1 | Channel field write strobe |
| ch_sel | input | CH_W | Channel index for the write |
| ch_en | input | 1 | Written output-enable |
| ch_cen | input | 1 | Written complementary-enable |
| ch_mode | input | MODE_W | Written output mode |
| cfg_wr | input | 1 | Writes the preload and update-select bits |
| cfg_preload | input | 1 | New preload bit |
| cfg_update_sel | input | 1 | New update-select bit (1 lets the trigger cause events) |
| com_sw_set | input | 1 | Software commutation generate strobe |
| trig_in | input | 1 | Asynchronous commutation trigger |
| flag_wr | input | 1 | Status flag write strobe |
| flag_wdata | input | 1 | Status flag write data (0 clears) |
| act_en | output | NUM_CH | Active output-enable per channel |
| act_cen | output | NUM_CH | Active complementary-enable per channel |
| act_mode | output | NUM_CH*MODE_W | Active mode fields, channel i at bits i*MODE_W upward |
| com_gen | output | 1 | Generate bit readback |
| com_flag | output | 1 | Sticky commutation status flag |

## Verification
Direct writes and software strobes are due on the outputs right after the single clock edge that accepts them. Trigger-caused transfers are due three edges after the trigger level changes, because of the two-stage synchroniser and the edge register. The bench drives inputs just after the falling edge and compares every output at the next falling edge. It checks against a behavioural model that holds the trigger history as a queue. Directed checks sample exactly at the cycles named above, including the two edges before a trigger transfer, where nothing may yet have changed.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    parameter int unsigned NUM_CH      = 4;
    parameter int unsigned NUM_COMP    = 3;
    parameter int unsigned MODE_W      = 3;
    parameter int unsigned SYNC_STAGES = 2;

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic              en;
        logic              cen;
        logic [MODE_W-1:0] mode;
    } chan_ctrl_t;

    localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

    function automatic logic [NUM_CH-1:0] comp_mask();
        logic [NUM_CH-1:0] m;
        for (int i = 0; i < NUM_CH; i++) m[i] = (i < NUM_COMP);
        return m;
    endfunction

    localparam logic [NUM_CH-1:0] COMP_MASK = comp_mask();

    function automatic chan_ctrl_t fit_channel(chan_ctrl_t v, logic has_comp);
        chan_ctrl_t r;
        r = v;
        if (!has_comp) r.cen = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/pcc_trig_sync.sv
module pcc_trig_sync
    import pcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic trig_rise
);
    logic [SYNC_STAGES-1:0] stage_q;
    logic                   last_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else if (g == 0) stage_q[g] <= trig_in;
                else stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= stage_q[SYNC_STAGES-1];
    end

    assign trig_rise = stage_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/pcc_evt_ctrl.sv
module pcc_evt_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr,
    input  logic cfg_preload,
    input  logic cfg_update_sel,
    input  logic com_sw_set,
    input  logic trig_rise,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic preload_q,
    output logic update_sel_q,
    output logic com_evt,
    output logic com_gen_q,
    output logic com_flag_q
);
    assign com_evt = com_sw_set | (update_sel_q & trig_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            preload_q    <= 1'b0;
            update_sel_q <= 1'b0;
        end else if (cfg_wr) begin
            preload_q    <= cfg_preload;
            update_sel_q <= cfg_update_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) com_gen_q <= 1'b0;
        else     com_gen_q <= com_sw_set;
    end

    always_ff @(posedge clk) begin
        if (rst)                         com_flag_q <= 1'b0;
        else if (com_evt)                com_flag_q <= 1'b1;
        else if (flag_wr && !flag_wdata) com_flag_q <= 1'b0;
    end
endmodule

// File: rtl/pcc_chan.sv
module pcc_chan
    import pcc_pkg::*;
#(
    parameter bit HAS_COMP = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  chan_ctrl_t wr_val,
    input  logic       preload,
    input  logic       com_evt,
    output chan_ctrl_t act
);
    chan_ctrl_t wr_fit;
    assign wr_fit = fit_channel(wr_val, HAS_COMP);

    generate
        if (HAS_COMP) begin : g_buffered
            chan_ctrl_t shadow_q;
            chan_ctrl_t shadow_nx;
            assign shadow_nx = wr_hit ? wr_fit : shadow_q;

            always_ff @(posedge clk) begin
                if (rst) shadow_q <= '0;
                else     shadow_q <= shadow_nx;
            end

            always_ff @(posedge clk) begin
                if (rst)                      act <= '0;
                else if (com_evt)             act <= shadow_nx;
                else if (wr_hit && !preload)  act <= wr_fit;
            end
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst)         act <= '0;
                else if (wr_hit) act <= wr_fit;
            end
        end
    endgenerate
endmodule

// File: rtl/pcc_latch.sv
module pcc_latch
    import pcc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ch_wr,
    input  logic [CH_W-1:0]          ch_sel,
    input  logic                     ch_en,
    input  logic                     ch_cen,
    input  logic [MODE_W-1:0]        ch_mode,
    input  logic                     cfg_wr,
    input  logic                     cfg_preload,
    input  logic                     cfg_update_sel,
    input  logic                     com_sw_set,
    input  logic                     trig_in,
    input  logic                     flag_wr,
    input  logic                     flag_wdata,
    output logic [NUM_CH-1:0]        act_en,
    output logic [NUM_CH-1:0]        act_cen,
    output logic [NUM_CH*MODE_W-1:0] act_mode,
    output logic                     com_gen,
    output logic                     com_flag
);
    logic       trig_rise;
    logic       preload_q;
    logic       update_sel_q;
    logic       com_evt;
    chan_ctrl_t wr_val;
    chan_ctrl_t act_fields [NUM_CH];

    assign wr_val = '{en: ch_en, cen: ch_cen, mode: ch_mode};

    pcc_trig_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .trig_rise (trig_rise)
    );

    pcc_evt_ctrl u_evt (
        .clk            (clk),
        .rst            (rst),
        .cfg_wr         (cfg_wr),
        .cfg_preload    (cfg_preload),
        .cfg_update_sel (cfg_update_sel),
        .com_sw_set     (com_sw_set),
        .trig_rise      (trig_rise),
        .flag_wr        (flag_wr),
        .flag_wdata     (flag_wdata),
        .preload_q      (preload_q),
        .update_sel_q   (update_sel_q),
        .com_evt        (com_evt),
        .com_gen_q      (com_gen),
        .com_flag_q     (com_flag)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic hit;
            assign hit = ch_wr && (ch_sel == CH_W'(c));

            pcc_chan #(.HAS_COMP(c < NUM_COMP)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .wr_hit  (hit),
                .wr_val  (wr_val),
                .preload (preload_q),
                .com_evt (com_evt),
                .act     (act_fields[c])
            );

            assign act_en[c]                    = act_fields[c].en;
            assign act_cen[c]                   = act_fields[c].cen;
            assign act_mode[c*MODE_W +: MODE_W] = act_fields[c].mode;
        end
    endgenerate
endmodule

// File: rtl/pcc_latch_chk.sv
module pcc_latch_chk
    import pcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              com_sw_set,
    input logic              com_evt,
    input logic              trig_rise,
    input logic              preload_q,
    input logic              update_sel_q,
    input logic              com_gen,
    input logic              com_flag,
    input logic              flag_wr,
    input logic              flag_wdata,
    input logic [NUM_CH-1:0] act_en,
    input logic [NUM_CH-1:0] act_cen
);
    AST_GEN_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
        com_gen |-> $past(com_sw_set)); // R9
    AST_GEN_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !com_sw_set |=> !com_gen); // R9
    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        com_evt |=> com_flag); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !flag_wdata && !com_evt) |=> !com_flag); // R10
    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (preload_q && !com_evt) |=> ($stable(act_en & COMP_MASK) && $stable(act_cen & COMP_MASK))); // R3
    AST_SEL0_NO_TRIG: assert property (@(posedge clk) disable iff (rst)
        (!update_sel_q && !com_sw_set) |-> !com_evt); // R4
    AST_NONCOMP_CEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (act_cen & ~COMP_MASK) == '0); // R7
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_rise |=> !trig_rise); // R11
endmodule

bind pcc_latch pcc_latch_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .com_sw_set   (com_sw_set),
    .com_evt      (com_evt),
    .trig_rise    (trig_rise),
    .preload_q    (preload_q),
    .update_sel_q (update_sel_q),
    .com_gen      (com_gen),
    .com_flag     (com_flag),
    .flag_wr      (flag_wr),
    .flag_wdata   (flag_wdata),
    .act_en       (act_en),
    .act_cen      (act_cen)
);

// File: tb/pcc_latch_bench.sv
`timescale 1ns/1ps
module pcc_latch_bench;
    import pcc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ch_wr = 0, ch_en = 0, ch_cen = 0, cfg_wr = 0, cfg_preload = 0, cfg_update_sel = 0;
    logic com_sw_set = 0, trig_in = 0, flag_wr = 0, flag_wdata = 0;
    logic [CH_W-1:0]          ch_sel = '0;
    logic [MODE_W-1:0]        ch_mode = '0;
    logic [NUM_CH-1:0]        act_en, act_cen;
    logic [NUM_CH*MODE_W-1:0] act_mode;
    logic                     com_gen, com_flag;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    pcc_latch u_pcc_latch (.*);

    // behavioural reference
    int m_en[NUM_CH], m_cen[NUM_CH], m_mode[NUM_CH];
    int s_en[NUM_CH], s_cen[NUM_CH], s_mode[NUM_CH];
    int m_pre = 0, m_sel = 0, m_gen = 0, m_flag = 0;
    int trig_hist[$];

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_en[i]) begin
                m_en[i] = 0; m_cen[i] = 0; m_mode[i] = 0;
                s_en[i] = 0; s_cen[i] = 0; s_mode[i] = 0;
            end
            m_pre = 0; m_sel = 0; m_gen = 0; m_flag = 0;
            trig_hist = '{0, 0, 0};
        end else begin
            bit rise, evt;
            rise = (trig_hist[1] == 1) && (trig_hist[2] == 0);
            evt  = com_sw_set || (m_sel != 0 && rise);
            trig_hist.push_front(int'(trig_in));
            void'(trig_hist.pop_back());
            for (int i = 0; i < NUM_CH; i++) begin
                bit comp;
                comp = (i < NUM_COMP);
                if (ch_wr && ch_sel == i) begin
                    s_en[i] = ch_en; s_cen[i] = comp ? ch_cen : 0; s_mode[i] = ch_mode;
                    if (!comp || m_pre == 0) begin
                        m_en[i] = s_en[i]; m_cen[i] = s_cen[i]; m_mode[i] = s_mode[i];
                    end
                end
                if (evt && comp) begin
                    m_en[i] = s_en[i]; m_cen[i] = s_cen[i]; m_mode[i] = s_mode[i];
                end
            end
            m_gen = com_sw_set;
            if (evt) m_flag = 1;
            else if (flag_wr && !flag_wdata) m_flag = 0;
            if (cfg_wr) begin
                m_pre = cfg_preload; m_sel = cfg_update_sel;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NUM_CH; i++) begin
                chk(phase, act_en[i], m_en[i]);
                chk(phase, act_cen[i], m_cen[i]);
                chk(phase, int'(act_mode[i*MODE_W +: MODE_W]), m_mode[i]);
            end
            chk(phase, com_gen, m_gen);
            chk(phase, com_flag, m_flag);
        end
    end

    function automatic int mode_of(int ch);
        return int'(act_mode[ch*MODE_W +: MODE_W]);
    endfunction

    task automatic cyc(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_ch(int ch, bit en, bit cen, int mode);
        ch_wr = 1; ch_sel = CH_W'(ch); ch_en = en; ch_cen = cen; ch_mode = MODE_W'(mode);
    endtask

    task automatic idle();
        ch_wr = 0; cfg_wr = 0; com_sw_set = 0; flag_wr = 0;
    endtask

    task automatic set_cfg(bit pre, bit sel);
        cfg_wr = 1; cfg_preload = pre; cfg_update_sel = sel;
        cyc(); idle();
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R1", int'(act_en), 0); chk("R1", int'(act_mode), 0);
        chk("R1", com_flag, 0); chk("R1", com_gen, 0);
        rst = 0;
        cyc();
        chk("R1", int'(act_cen), 0);

        phase = "R2";
        wr_ch(0, 1, 1, 5); cyc(); idle();
        chk("R2", act_en[0], 1); chk("R2", mode_of(0), 5);

        phase = "R3";
        set_cfg(1, 0);
        wr_ch(1, 1, 1, 3); cyc(); idle();
        chk("R3", act_en[1], 0); chk("R3", mode_of(1), 0);
        cyc(2);
        chk("R3", mode_of(1), 0);

        phase = "R6";
        com_sw_set = 1; cyc(); idle();
        chk("R6", mode_of(1), 3); chk("R6", act_cen[1], 1); chk("R10", com_flag, 1);
        chk("R9", com_gen, 1);
        cyc();
        chk("R9", com_gen, 0); chk("R10", com_flag, 1);

        phase = "R10";
        flag_wr = 1; flag_wdata = 1; cyc(); idle();
        chk("R10", com_flag, 1);
        flag_wr = 1; flag_wdata = 0; cyc(); idle();
        chk("R10", com_flag, 0);
        flag_wr = 1; flag_wdata = 0; com_sw_set = 1; cyc(); idle();
        chk("R10", com_flag, 1);
        flag_wr = 1; flag_wdata = 0; cyc(); idle();

        phase = "R4";
        wr_ch(2, 1, 0, 6); cyc(); idle();
        trig_in = 1; cyc(6); trig_in = 0; cyc(4);
        chk("R4", mode_of(2), 0); chk("R4", com_flag, 0);

        phase = "R5";
        set_cfg(1, 1);
        trig_in = 1;
        cyc(2);
        chk("R5", mode_of(2), 0); chk("R5", com_flag, 0);
        cyc();
        chk("R5", mode_of(2), 6); chk("R5", act_en[2], 1); chk("R5", com_flag, 1);

        phase = "R11";
        flag_wr = 1; flag_wdata = 0; cyc(); idle();
        wr_ch(2, 0, 1, 1); cyc(); idle();
        cyc(6);
        chk("R11", mode_of(2), 6); chk("R11", com_flag, 0);
        trig_in = 0; cyc(4);

        phase = "R7";
        wr_ch(NUM_CH - 1, 1, 1, 7); cyc(); idle();
        chk("R7", act_en[NUM_CH-1], 1); chk("R7", act_cen[NUM_CH-1], 0);
        chk("R7", mode_of(NUM_CH - 1), 7);

        phase = "R8";
        wr_ch(0, 0, 1, 2); com_sw_set = 1; cyc(); idle();
        chk("R8", mode_of(0), 2); chk("R8", act_en[0], 0);
        chk("R8", mode_of(2), 1);

        phase = "R2";
        set_cfg(0, 0);
        for (int n = 0; n < 600; n++) begin
            if (n == 300) phase = "R3";
            ch_wr = ($urandom % 3) == 0; ch_sel = CH_W'($urandom);
            ch_en = $urandom; ch_cen = $urandom; ch_mode = MODE_W'($urandom);
            cfg_wr = ($urandom % 23) == 0; cfg_preload = $urandom; cfg_update_sel = $urandom;
            com_sw_set = ($urandom % 11) == 0;
            flag_wr = ($urandom % 7) == 0; flag_wdata = $urandom;
            if (($urandom % 5) == 0) trig_in = ~trig_in;
            cyc();
        end
        idle();
        cyc(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule